// File: doc/BRIEF.md
# Three-Port Per-Core Auxiliary RAM

This block is a small word-wide scratch memory placed next to each processor core. It has three clients, and each one owns a port. The core reads and writes through its own port. The shared-memory side also reads and writes, through a second port that does not depend on the first. A display engine reads through a third port, which is read-only. All three ports may operate in the same clock cycle, and none of them is ever stalled. The display engine can therefore stream pixels while the other two clients update the contents.

Every read is synchronous and takes one cycle. A port's read data register loads the addressed word at the clock edge where the read is sampled, and it holds that value until the port reads again. When a word is read in the same cycle that it is written, the reader gets the value from before the write. Core and shared-side writes to different words in one cycle both take effect. When both write the same word in one cycle, the core write is kept, the shared-side write is dropped, and a collision flag reports the event.

The collision flag comes from a two-state machine. CLASH_QUIET is the reset state and holds the flag low. CLASH_QUIET moves to CLASH_FLAG in any cycle where the arbiter sees a same-word double write. CLASH_FLAG drives the flag high for one cycle. It stays in CLASH_FLAG if another collision is sampled in that cycle, and otherwise it returns to CLASH_QUIET.

Top module: `aux3_ram`

## Requirements
- R1: After reset, all three read data outputs are zero, the collision flag is low, and every one of the 256 words reads as zero.
- R2: A core write (core_en=1, core_we=1) stores core_wdata at core_addr. A core read (core_en=1, core_we=0) drives the stored word on core_rdata from the cycle after it is sampled.
- R3: A shared-side write (hub_en=1, hub_we=1) stores hub_wdata at hub_addr unless it collides (R7). A shared-side read (hub_en=1, hub_we=0) drives the stored word on hub_rdata one cycle later.
- R4: A display read (vid_en=1) drives the word at vid_addr on vid_rdata one cycle later, in every cycle, whatever the other two ports are doing.
- R5: A read of a word that is written in the same cycle, on any port, returns the word's value from before that write.
- R6: A core write and a shared-side write to different addresses in the same cycle both take effect.
- R7: When the core and the shared side write the same address in the same cycle, the word takes core_wdata and hub_wdata is discarded.
- R8: wr_clash is high for exactly the one cycle that follows each cycle with a same-address double write, and low at all other times. A same-address pair where one side only reads, or where a port is not enabled, is not a collision.
- R9: A port's read data holds its value in any cycle where that port does not read (port not enabled, or, for core and shared side, a write cycle).
- R10: Reads on all three ports in one cycle, to the same address or to different addresses, each return the correct word, including under random mixed traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | Core port access enable |
| core_we | input | 1 | Core port write (1) or read (0) |
| core_addr | input | 8 | Core port word address |
| core_wdata | input | 32 | Core port write data |
| core_rdata | output | 32 | Core port read data |
| hub_en | input | 1 | Shared-side port access enable |
| hub_we | input | 1 | Shared-side write (1) or read (0) |
| hub_addr | input | 8 | Shared-side word address |
| hub_wdata | input | 32 | Shared-side write data |
| hub_rdata | output | 32 | Shared-side read data |
| vid_en | input | 1 | Display port read enable |
| vid_addr | input | 8 | Display port word address |
| vid_rdata | output | 32 | Display port read data |
| wr_clash | output | 1 | One-cycle pulse after a same-address double write |

## Verification
A corrupted storage word shows up on a port at the first later read of that address, one cycle after the read is sampled. Because random traffic is confined to a few addresses much of the time, such a read usually follows within a handful of cycles. A wrong arbitration result shows up as the shared-side value in a word that should hold the core value, or as a wr_clash pulse that is missing or extra, visible one cycle after the colliding edge. A read register that loads when it should hold shows up as a changed output during an idle or write cycle, in the very next sample.

// File: rtl/aux3_pkg.sv
package aux3_pkg;

    localparam int AUX_ADDR_W   = 8;
    localparam int AUX_DATA_W   = 32;
    localparam int AUX_RD_LANES = 3;

    localparam int LANE_CORE = 0;
    localparam int LANE_HUB  = 1;
    localparam int LANE_VID  = 2;

    typedef enum logic {
        CLASH_QUIET = 1'b0,
        CLASH_FLAG  = 1'b1
    } clash_state_e;

endpackage

// File: rtl/aux3_write_arb.sv
module aux3_write_arb #(
    parameter int ADDR_W = aux3_pkg::AUX_ADDR_W,
    parameter int DATA_W = aux3_pkg::AUX_DATA_W
) (
    input  logic              core_en,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              hub_en,
    input  logic              hub_we,
    input  logic [ADDR_W-1:0] hub_addr,
    input  logic [DATA_W-1:0] hub_wdata,
    output logic              lane_a_we,
    output logic [ADDR_W-1:0] lane_a_addr,
    output logic [DATA_W-1:0] lane_a_data,
    output logic              lane_b_we,
    output logic [ADDR_W-1:0] lane_b_addr,
    output logic [DATA_W-1:0] lane_b_data,
    output logic              clash_now
);

    logic core_wr;
    logic hub_wr;
    logic same_word;

    always_comb begin
        core_wr   = core_en & core_we;
        hub_wr    = hub_en & hub_we;
        same_word = (core_addr == hub_addr);
        clash_now = core_wr & hub_wr & same_word;
    end

    // Lane A carries the core write and always wins; lane B carries the
    // shared-side write and is suppressed on a same-word clash.
    always_comb begin
        lane_a_we   = core_wr;
        lane_a_addr = core_addr;
        lane_a_data = core_wdata;
        lane_b_we   = hub_wr & ~clash_now;
        lane_b_addr = hub_addr;
        lane_b_data = hub_wdata;
    end

endmodule

// File: rtl/aux3_store.sv
module aux3_store #(
    parameter int ADDR_W = aux3_pkg::AUX_ADDR_W,
    parameter int DATA_W = aux3_pkg::AUX_DATA_W,
    parameter int LANES  = aux3_pkg::AUX_RD_LANES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lane_a_we,
    input  logic [ADDR_W-1:0]           lane_a_addr,
    input  logic [DATA_W-1:0]           lane_a_data,
    input  logic                        lane_b_we,
    input  logic [ADDR_W-1:0]           lane_b_addr,
    input  logic [DATA_W-1:0]           lane_b_data,
    input  logic [LANES-1:0][ADDR_W-1:0] rd_addr,
    output logic [LANES-1:0][DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else begin
            if (lane_b_we) begin
                cells[lane_b_addr] <= lane_b_data;
            end
            if (lane_a_we) begin
                cells[lane_a_addr] <= lane_a_data;
            end
        end
    end

    // Combinational taps of the pre-edge contents: registering these in
    // the read ports yields old data on a same-cycle write.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_word[l] = cells[rd_addr[l]];
        end
    end

    always_comb begin
        if (rst_n) begin
            assert_lanes_disjoint_R7: assert (!(lane_a_we && lane_b_we &&
                                                (lane_a_addr == lane_b_addr)))
                else $error("both write lanes target one word");
        end
    end

    assert_core_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_a_we |=> cells[$past(lane_a_addr)] == $past(lane_a_data))
        else $error("core lane write lost");

    assert_hub_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_b_we |=> cells[$past(lane_b_addr)] == $past(lane_b_data))
        else $error("shared lane write lost");

endmodule

// File: rtl/aux3_read_port.sv
module aux3_read_port #(
    parameter int DATA_W = aux3_pkg::AUX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (take) begin
            rdata <= word_in;
        end
    end

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rdata))
        else $error("read data moved without a read");

endmodule

// File: rtl/aux3_clash_flag.sv
module aux3_clash_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clash_now,
    output logic flag
);

    import aux3_pkg::*;

    clash_state_e state;
    clash_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CLASH_QUIET;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            CLASH_QUIET: if (clash_now)  state_nxt = CLASH_FLAG;
            CLASH_FLAG:  if (!clash_now) state_nxt = CLASH_QUIET;
            default:     state_nxt = CLASH_QUIET;
        endcase
    end

    always_comb begin
        unique case (state)
            CLASH_QUIET: flag = 1'b0;
            CLASH_FLAG:  flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/aux3_ram.sv
module aux3_ram #(
    parameter int ADDR_W = aux3_pkg::AUX_ADDR_W,
    parameter int DATA_W = aux3_pkg::AUX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              hub_en,
    input  logic              hub_we,
    input  logic [ADDR_W-1:0] hub_addr,
    input  logic [DATA_W-1:0] hub_wdata,
    output logic [DATA_W-1:0] hub_rdata,
    input  logic              vid_en,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_rdata,
    output logic              wr_clash
);

    import aux3_pkg::*;

    localparam int LANES = AUX_RD_LANES;

    logic              a_we;
    logic [ADDR_W-1:0] a_addr;
    logic [DATA_W-1:0] a_data;
    logic              b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_data;
    logic              clash_now;

    logic [LANES-1:0]             rd_take;
    logic [LANES-1:0][ADDR_W-1:0] rd_addr;
    logic [LANES-1:0][DATA_W-1:0] rd_word;
    logic [LANES-1:0][DATA_W-1:0] rd_q;

    aux3_write_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .core_en    (core_en),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .hub_en     (hub_en),
        .hub_we     (hub_we),
        .hub_addr   (hub_addr),
        .hub_wdata  (hub_wdata),
        .lane_a_we  (a_we),
        .lane_a_addr(a_addr),
        .lane_a_data(a_data),
        .lane_b_we  (b_we),
        .lane_b_addr(b_addr),
        .lane_b_data(b_data),
        .clash_now  (clash_now)
    );

    always_comb begin
        rd_take[LANE_CORE] = core_en & ~core_we;
        rd_take[LANE_HUB]  = hub_en & ~hub_we;
        rd_take[LANE_VID]  = vid_en;
        rd_addr[LANE_CORE] = core_addr;
        rd_addr[LANE_HUB]  = hub_addr;
        rd_addr[LANE_VID]  = vid_addr;
    end

    aux3_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_a_we  (a_we),
        .lane_a_addr(a_addr),
        .lane_a_data(a_data),
        .lane_b_we  (b_we),
        .lane_b_addr(b_addr),
        .lane_b_data(b_data),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        aux3_read_port #(.DATA_W(DATA_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (rd_take[g]),
            .word_in(rd_word[g]),
            .rdata  (rd_q[g])
        );
    end

    assign core_rdata = rd_q[LANE_CORE];
    assign hub_rdata  = rd_q[LANE_HUB];
    assign vid_rdata  = rd_q[LANE_VID];

    aux3_clash_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .clash_now(clash_now),
        .flag     (wr_clash)
    );

    assert_clash_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clash |-> $past(core_en && core_we && hub_en && hub_we &&
                           (core_addr == hub_addr)))
        else $error("collision pulse without a double write");

    assert_clash_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && core_we && hub_en && hub_we && (core_addr == hub_addr))
            |=> wr_clash)
        else $error("double write not reported");

    assert_vid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |=> $stable(vid_rdata))
        else $error("display data moved while idle");

endmodule

// File: tb/test_aux3_ram.sv
module test_aux3_ram;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_en = 1'b0, core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;
    logic          hub_en = 1'b0, hub_we = 1'b0;
    logic [AW-1:0] hub_addr = '0;
    logic [DW-1:0] hub_wdata = '0;
    logic [DW-1:0] hub_rdata;
    logic          vid_en = 1'b0;
    logic [AW-1:0] vid_addr = '0;
    logic [DW-1:0] vid_rdata;
    logic          wr_clash;

    always #10 clk = ~clk;

    aux3_ram #(.ADDR_W(AW), .DATA_W(DW)) i_aux3_ram (
        .clk(clk), .rst_n(rst_n),
        .core_en(core_en), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .hub_en(hub_en), .hub_we(hub_we), .hub_addr(hub_addr),
        .hub_wdata(hub_wdata), .hub_rdata(hub_rdata),
        .vid_en(vid_en), .vid_addr(vid_addr), .vid_rdata(vid_rdata),
        .wr_clash(wr_clash)
    );

    logic [DW-1:0] model [NW];
    logic [DW-1:0] exp_core, exp_hub, exp_vid;
    logic          exp_clash;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    function automatic logic is_clash(logic ce, logic cw, logic [AW-1:0] ca,
                                      logic he, logic hw, logic [AW-1:0] ha);
        return ce && cw && he && hw && (ca == ha);
    endfunction

    task automatic chk(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic check_all(string rq);
        chk(rq, "core_rdata", core_rdata, exp_core);
        chk(rq, "hub_rdata", hub_rdata, exp_hub);
        chk(rq, "vid_rdata", vid_rdata, exp_vid);
        chk(rq, "wr_clash", {31'b0, wr_clash}, {31'b0, exp_clash});
    endtask

    // Called at a negative edge: drive, let the design sample, update the
    // bench model, then compare at the following negative edge.
    task automatic cyc(input logic ce, input logic cw, input logic [AW-1:0] ca,
                       input logic [DW-1:0] cd,
                       input logic he, input logic hw, input logic [AW-1:0] ha,
                       input logic [DW-1:0] hd,
                       input logic ve, input logic [AW-1:0] va, input string rq);
        core_en = ce; core_we = cw; core_addr = ca; core_wdata = cd;
        hub_en = he; hub_we = hw; hub_addr = ha; hub_wdata = hd;
        vid_en = ve; vid_addr = va;
        @(posedge clk);
        exp_clash = is_clash(ce, cw, ca, he, hw, ha);
        if (ce && !cw) exp_core = model[ca];
        if (he && !hw) exp_hub = model[ha];
        if (ve) exp_vid = model[va];
        if (he && hw && !exp_clash) model[ha] = hd;
        if (ce && cw) model[ca] = cd;
        @(negedge clk);
        check_all(rq);
    endtask

    task automatic idle(string rq);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        exp_core = '0; exp_hub = '0; exp_vid = '0; exp_clash = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs after reset, then every word reads zero
        check_all("R1");
        for (int a = 0; a < NW; a++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, AW'(a), "R1");

        // R2: core write then core read
        cyc(1, 1, 8'h21, 32'hA5A5_0001, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 8'h21, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3: shared-side write, then read on shared side and display
        cyc(0, 0, 0, 0, 1, 1, 8'h42, 32'h5A5A_0002, 0, 0, "R3");
        cyc(0, 0, 0, 0, 1, 0, 8'h42, 0, 1, 8'h42, "R3");
        // R4: display reads while both other ports write elsewhere
        cyc(1, 1, 8'h50, 32'h1111_0050, 1, 1, 8'h51, 32'h2222_0051, 1, 8'h21, "R4");
        cyc(1, 1, 8'h52, 32'h3333_0052, 1, 1, 8'h53, 32'h4444_0053, 1, 8'h50, "R4");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h53, "R4");
        // R5: read-during-write returns old contents
        cyc(1, 1, 8'h21, 32'hDEAD_0021, 1, 0, 8'h21, 0, 1, 8'h21, "R5");
        cyc(1, 0, 8'h42, 0, 1, 1, 8'h42, 32'hBEEF_0042, 1, 8'h42, "R5");
        cyc(1, 0, 8'h21, 0, 1, 0, 8'h42, 0, 1, 8'h21, "R5");
        // R6: disjoint double write, then read back both
        cyc(1, 1, 8'h10, 32'hC0DE_0010, 1, 1, 8'h11, 32'hF00D_0011, 0, 0, "R6");
        cyc(1, 0, 8'h11, 0, 1, 0, 8'h10, 0, 1, 8'h10, "R6");
        // R7/R8: same-word collision, core value kept, pulse one cycle
        cyc(1, 1, 8'h30, 32'hC0C0_0030, 1, 1, 8'h30, 32'hBADB_AD30, 0, 0, "R7");
        cyc(1, 0, 8'h30, 0, 1, 0, 8'h30, 0, 1, 8'h30, "R7");
        cyc(1, 1, 8'h31, 32'h0000_0A31, 1, 1, 8'h31, 32'h0000_0B31, 0, 0, "R8");
        cyc(1, 1, 8'h32, 32'h0000_0A32, 1, 1, 8'h32, 32'h0000_0B32, 0, 0, "R8");
        idle("R8");
        cyc(1, 1, 8'h33, 32'h0000_0A33, 1, 0, 8'h33, 0, 0, 0, "R8");
        cyc(0, 1, 8'h34, 32'h0000_0A34, 1, 1, 8'h34, 32'h0000_0B34, 0, 0, "R8");
        cyc(1, 0, 8'h31, 0, 1, 0, 8'h34, 0, 1, 8'h32, "R8");
        // R9: outputs hold when idle or writing
        idle("R9");
        cyc(0, 1, 8'h00, 32'hFFFF_FFFF, 0, 1, 8'h01, 32'hFFFF_FFFF, 0, 0, "R9");
        cyc(1, 1, 8'h60, 32'h0000_0060, 1, 1, 8'h61, 32'h0000_0061, 0, 0, "R9");
        // R10: three reads to one address, then random mixed traffic
        cyc(1, 0, 8'h60, 0, 1, 0, 8'h60, 0, 1, 8'h60, "R10");
        void'($urandom(32'h5EED_0A3));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r, m;
            logic [AW-1:0] ca, ha, va;
            r = $urandom;
            m = (r[31:30] == 2'b00) ? 32'hFF : 32'h0F;
            ca = AW'($urandom & m);
            ha = AW'($urandom & m);
            va = AW'($urandom & m);
            cyc(r[0], r[1], ca, $urandom, r[2], r[3], ha, $urandom, r[4], va, "R10");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule